// File: doc/BRIEF.md
# Condition Flag Register and Branch Condition Evaluator

This block sits beside the execute stage of a small pipelined integer core. It keeps three status flags (zero, sign, overflow) that describe the last integer arithmetic or logic result that was allowed to commit. From those stored flags and the function field of the instruction now in execute, it produces a single condition bit. The core uses that bit to decide whether a conditional jump is taken or whether a conditional register move writes its destination.

Only instructions of the integer-operation class may write the flags. Exception control can hold a suppress input high while an older instruction carrying an exception is further down the pipeline. A flag write in that cycle is then discarded, so that no instruction behind the faulting one changes state that the program can see. The ALU itself supplies the result word and the sign bits of its two operands. This block does not redo the arithmetic.

Top module: `cc_branch_unit`

## Requirements
- R1: A synchronous, active-high `rst` sets the flags to zero=1, sign=0, overflow=0.
- R2: The flags load a new value on a rising clock edge only when `ex_icode` is 6 (the integer-operation class). Any other `ex_icode` leaves all three flags unchanged.
- R3: When `exc_block` is high, no flag changes on that edge, even when `ex_icode` is 6.
- R4: On a flag load, zero is set exactly when every bit of `alu_res` is 0.
- R5: On a flag load, sign takes the most significant bit of `alu_res`.
- R6: On a flag load, overflow is computed from `ex_ifun` as follows:
  - Function 0 (add): overflow is set when both operand signs are equal and the result sign differs from them.
  - Function 1 (subtract, result = A - B): overflow is set when the operand signs differ and the result sign differs from the sign of A.
  - Every other function code is a logic operation and clears overflow.
- R7: When `ex_icode` is 7 (jump) or 2 (conditional move), `cond_true` is set from `ex_ifun`, with L = S xor O:
  - 0: always 1.
  - 1: L or Z.
  - 2: L.
  - 3: Z.
  - 4: not Z.
  - 5: not L.
  - 6: (not L) and (not Z).
  - 7 to 15: 0.
- R8: `cond_true` is 0 for every `ex_icode` other than 7 and 2.
- R9: `cond_true` is combinational from the stored flags. A conditional instruction in the cycle right after a flag load sees the new flags with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ex_icode | input | 4 | Instruction class of the execute-stage instruction |
| ex_ifun | input | 4 | Function field of the execute-stage instruction |
| alu_res | input | 32 | ALU result word |
| opa_neg | input | 1 | Sign bit of ALU operand A |
| opb_neg | input | 1 | Sign bit of ALU operand B |
| exc_block | input | 1 | Suppresses flag writes while an older exception is pending |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored overflow flag |
| cond_true | output | 1 | Condition result for jump or conditional move |

## Verification
The hardest case is a flag state in which the zero and overflow flags are both set. A real ALU produces this only from a wrapped signed addition, such as two negative operands whose sum is exactly zero. The bench reaches it by driving the operand sign inputs and the result word independently. It cycles through six flag-setting vectors chosen so that together they cover every reachable combination of zero, sign and overflow. After each vector it sweeps all 256 class and function pairs against the stored flags. During that sweep the suppress input is raised only for the integer-operation class. This one sweep therefore also confirms that suppression works and that every other class leaves the flags alone.

// File: rtl/cc_branch_pkg.sv
package cc_branch_pkg;

  localparam int unsigned CODE_W = 4;

  localparam logic [CODE_W-1:0] CLS_INTOP = 4'h6;
  localparam logic [CODE_W-1:0] CLS_JUMP  = 4'h7;
  localparam logic [CODE_W-1:0] CLS_CMOV  = 4'h2;

  localparam logic [CODE_W-1:0] FN_ADD = 4'h0;
  localparam logic [CODE_W-1:0] FN_SUB = 4'h1;

  typedef enum logic [CODE_W-1:0] {
    CT_ALWAYS = 4'h0,
    CT_LE     = 4'h1,
    CT_LT     = 4'h2,
    CT_EQ     = 4'h3,
    CT_NE     = 4'h4,
    CT_GE     = 4'h5,
    CT_GT     = 4'h6
  } cond_kind_e;

  typedef struct packed {
    logic z;
    logic s;
    logic o;
  } cc_t;

  localparam cc_t CC_RESET = '{z: 1'b1, s: 1'b0, o: 1'b0};

  // Signed overflow from operand signs and the result sign.
  function automatic logic ovf_of(input logic [CODE_W-1:0] fn,
                                  input logic an, input logic bn,
                                  input logic rn);
    logic v;
    if (fn == FN_ADD)      v = (an == bn) && (rn != an);
    else if (fn == FN_SUB) v = (an != bn) && (rn != an);
    else                   v = 1'b0;
    return v;
  endfunction

  // Condition outcome for a function field against stored flags.
  function automatic logic cond_of(input logic [CODE_W-1:0] fn,
                                   input cc_t f);
    logic lt;
    logic r;
    lt = f.s ^ f.o;
    case (fn)
      CT_ALWAYS: r = 1'b1;
      CT_LE:     r = lt | f.z;
      CT_LT:     r = lt;
      CT_EQ:     r = f.z;
      CT_NE:     r = ~f.z;
      CT_GE:     r = ~lt;
      CT_GT:     r = ~lt & ~f.z;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cc_flag_gen.sv
module cc_flag_gen
  import cc_branch_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [CODE_W-1:0] ifun,
  input  logic [DATA_W-1:0] res,
  input  logic              a_neg,
  input  logic              b_neg,
  output cc_t               nxt
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    nxt.z = (res == '0);
    nxt.s = res[MSB];
    nxt.o = ovf_of(ifun, a_neg, b_neg, res[MSB]);
  end
endmodule

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_branch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  cc_t  nxt,
  output cc_t  cur
);
  always_ff @(posedge clk) begin
    if (rst)        cur <= CC_RESET;
    else if (wr_en) cur <= nxt;
  end
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_branch_pkg::*;
(
  input  logic [CODE_W-1:0] icode,
  input  logic [CODE_W-1:0] ifun,
  input  cc_t               cur,
  output logic              cond
);
  logic is_cond_cls;

  always_comb begin
    is_cond_cls = (icode == CLS_JUMP) || (icode == CLS_CMOV);
    cond        = is_cond_cls & cond_of(ifun, cur);
  end
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_branch_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        ex_icode,
  input  logic [3:0]        ex_ifun,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              opa_neg,
  input  logic              opb_neg,
  input  logic              exc_block,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o,
  output logic              cond_true
);
  cc_t  nxt_cc;
  cc_t  cur_cc;
  logic upd_en;

  assign upd_en = (ex_icode == CLS_INTOP) && !exc_block;

  cc_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .ifun  (ex_ifun),
    .res   (alu_res),
    .a_neg (opa_neg),
    .b_neg (opb_neg),
    .nxt   (nxt_cc)
  );

  cc_flag_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr_en (upd_en),
    .nxt   (nxt_cc),
    .cur   (cur_cc)
  );

  cc_cond_eval u_cond (
    .icode (ex_icode),
    .ifun  (ex_ifun),
    .cur   (cur_cc),
    .cond  (cond_true)
  );

  assign flag_z = cur_cc.z;
  assign flag_s = cur_cc.s;
  assign flag_o = cur_cc.o;
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        ex_icode,
  input logic [3:0]        ex_ifun,
  input logic [DATA_W-1:0] alu_res,
  input logic              opa_neg,
  input logic              opb_neg,
  input logic              exc_block,
  input logic              upd_en,
  input logic              flag_z,
  input logic              flag_s,
  input logic              flag_o,
  input logic              cond_true
);
  logic [2:0] fl;
  logic       load;
  assign fl   = {flag_z, flag_s, flag_o};
  assign load = (ex_icode == 4'h6) && !exc_block;

  a_r1_reset_value: assert property (@(posedge clk)
    $past(rst) |-> (fl == 3'b100));

  a_r2_hold_other_class: assert property (@(posedge clk) disable iff (rst)
    (ex_icode != 4'h6) |=> $stable(fl));

  a_r3_blocked: assert property (@(posedge clk) disable iff (rst)
    exc_block |=> $stable(fl));

  a_r3_enable_agrees: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> !exc_block);

  a_r4_zero: assert property (@(posedge clk) disable iff (rst)
    load |=> (flag_z == ($past(alu_res) == '0)));

  a_r5_sign: assert property (@(posedge clk) disable iff (rst)
    load |=> (flag_s == $past(alu_res[DATA_W-1])));

  a_r6_logic_clears_o: assert property (@(posedge clk) disable iff (rst)
    (load && ex_ifun > 4'h1) |=> !flag_o);

  a_r6_add_wrap: assert property (@(posedge clk) disable iff (rst)
    (load && ex_ifun == 4'h0 && opa_neg == opb_neg &&
     alu_res[DATA_W-1] != opa_neg) |=> flag_o);

  a_r7_always: assert property (@(posedge clk) disable iff (rst)
    (ex_icode == 4'h7 && ex_ifun == 4'h0) |-> cond_true);

  a_r7_equal: assert property (@(posedge clk) disable iff (rst)
    (ex_icode == 4'h7 && ex_ifun == 4'h3) |-> (cond_true == flag_z));

  a_r8_other_class: assert property (@(posedge clk) disable iff (rst)
    (ex_icode != 4'h7 && ex_icode != 4'h2) |-> !cond_true);
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ex_icode  (ex_icode),
  .ex_ifun   (ex_ifun),
  .alu_res   (alu_res),
  .opa_neg   (opa_neg),
  .opb_neg   (opb_neg),
  .exc_block (exc_block),
  .upd_en    (upd_en),
  .flag_z    (flag_z),
  .flag_s    (flag_s),
  .flag_o    (flag_o),
  .cond_true (cond_true)
);

// File: tb/sim_cc_branch_unit.sv
`timescale 1ns/1ps
module sim_cc_branch_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ex_icode = 4'h0;
  logic [3:0]  ex_ifun = 4'h0;
  logic [31:0] alu_res = 32'h0;
  logic        opa_neg = 1'b0;
  logic        opb_neg = 1'b0;
  logic        exc_block = 1'b0;
  logic        flag_z, flag_s, flag_o, cond_true;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic mz, ms, mo;

  always #5 clk = ~clk;

  cc_branch_unit u0 (
    .clk(clk), .rst(rst), .ex_icode(ex_icode), .ex_ifun(ex_ifun),
    .alu_res(alu_res), .opa_neg(opa_neg), .opb_neg(opb_neg),
    .exc_block(exc_block), .flag_z(flag_z), .flag_s(flag_s),
    .flag_o(flag_o), .cond_true(cond_true)
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic exp_cond(input logic [3:0] ic, input logic [3:0] f);
    logic less;
    if (!(ic == 4'd7 || ic == 4'd2)) return 1'b0;
    less = (ms != mo);
    case (f)
      4'd0: return 1'b1;
      4'd1: return less || mz;
      4'd2: return less;
      4'd3: return mz;
      4'd4: return !mz;
      4'd5: return !less;
      4'd6: return !(less || mz);
      default: return 1'b0;
    endcase
  endfunction

  // Apply one integer op for one cycle, then check the flags at the next negedge.
  task automatic alu_op(input logic [3:0] f, input logic an, input logic bn,
                        input logic [31:0] r, input logic blk, input string req);
    logic rn;
    @(negedge clk);
    ex_icode = 4'd6; ex_ifun = f; opa_neg = an; opb_neg = bn;
    alu_res = r; exc_block = blk;
    rn = r[31];
    if (!blk) begin
      mz = (r == 32'd0);
      ms = rn;
      if (f == 4'd0)      mo = (an & bn & ~rn) | (~an & ~bn & rn);
      else if (f == 4'd1) mo = (an & ~bn & ~rn) | (~an & bn & rn);
      else                mo = 1'b0;
    end
    @(negedge clk);
    ex_icode = 4'd0; exc_block = 1'b0;
    check(req, {flag_z, flag_s, flag_o}, {mz, ms, mo});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0; pats[1] = 32'h1; pats[2] = 32'h8000_0000; pats[3] = 32'h7FFF_FFFF;
    mz = 1; ms = 0; mo = 0;

    // R1: reset state, with flags first disturbed while reset holds
    repeat (2) @(negedge clk);
    check("R1 reset", {flag_z, flag_s, flag_o}, 3'b100);
    ex_icode = 4'd6; alu_res = 32'h8000_0000; opa_neg = 0; opb_neg = 0;
    @(negedge clk);
    check("R1 reset dominates", {flag_z, flag_s, flag_o}, 3'b100);
    rst = 0; ex_icode = 4'd0;
    @(negedge clk);
    check("R1 after release", {flag_z, flag_s, flag_o}, 3'b100);

    // R4 R5 R6: sweep functions, sign pairs and result patterns; R3 with block
    for (int f = 0; f < 4; f++)
      for (int sg = 0; sg < 4; sg++)
        for (int p = 0; p < 4; p++) begin
          alu_op(4'(f), sg[1], sg[0], pats[p], 1'b0, "R4/R5/R6 flag load");
          alu_op(4'(f), ~sg[1], sg[0], ~pats[p], 1'b1, "R3 blocked load");
        end

    // R7 R8 R2 R3: all class/function pairs against each flag state
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: alu_op(4'd0, 1'b1, 1'b1, 32'h0, 1'b0, "R6 setup Z+O");
        1: alu_op(4'd0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, "R6 setup S+O");
        2: alu_op(4'd2, 1'b0, 1'b0, 32'h0, 1'b0, "R4 setup Z");
        3: alu_op(4'd3, 1'b1, 1'b0, 32'hF000_0000, 1'b0, "R5 setup S");
        4: alu_op(4'd1, 1'b1, 1'b0, 32'h7000_0000, 1'b0, "R6 setup O");
        default: alu_op(4'd1, 1'b0, 1'b0, 32'h5, 1'b0, "R6 setup none");
      endcase
      // R9: conditional instruction right after the load sees new flags
      @(negedge clk);
      ex_icode = 4'd7; ex_ifun = 4'd3; #1;
      check("R9 same-cycle use", {2'b00, cond_true}, {2'b00, mz});
      for (int ic = 0; ic < 16; ic++) begin
        for (int f = 0; f < 16; f++) begin
          @(negedge clk);
          ex_icode = 4'(ic); ex_ifun = 4'(f);
          alu_res = 32'hDEAD_BEEF; opa_neg = 1; opb_neg = 0;
          exc_block = (ic == 6);
          #1;
          check((ic == 7 || ic == 2) ? "R7 condition" : "R8 non-cond class",
                {2'b00, cond_true}, {2'b00, exp_cond(4'(ic), 4'(f))});
        end
        @(negedge clk);
        ex_icode = 4'd0; exc_block = 1'b0;
        check((ic == 6) ? "R3 block holds flags" : "R2 other class holds flags",
              {flag_z, flag_s, flag_o}, {mz, ms, mo});
      end
    end

    // R1: reset from a nonreset state
    alu_op(4'd0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, "R6 pre-reset");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    mz = 1; ms = 0; mo = 0;
    check("R1 second reset", {flag_z, flag_s, flag_o}, 3'b100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule